// File: doc/BRIEF.md
# Byte-Wide Hardware Stack Unit

This unit keeps a downward-growing stack inside a single 256-byte page at the bottom of memory and moves every 16-bit value through an 8-bit memory port, one byte per cycle. A sequencer accepts a one-cycle operation strobe with a 3-bit code. It can save or restore a general register value, save or restore a return address for subroutine call and return, load the stack pointer from the value presented on `wr_data`, or return the stack pointer as a 16-bit result. Each operation runs for a fixed number of cycles and ends with a single-cycle `done` pulse.

The register file and program-counter logic sit outside the unit. They present the value to be saved on `wr_data` together with the strobe, and they take a restored value from `rd_data` while `done` is high. Memory has a combinational read: `mem_rdata` must reflect `mem_addr` in the same cycle. The address is always zero in its upper byte, so stack traffic never leaves the page.

Cycle numbering: cycle 1 is the cycle in which `op_valid` is high and the unit is idle. The rising edge that ends cycle 1 accepts the operation, and cycle N is the last cycle of an N-cycle operation.

Top module: `byte_stack_unit`

## Requirements
- R1: After reset, `sp` is 0x0000, `rd_data` is 0x0000, and both `done` and `mem_we` are low.
- R2: A register save (code 0) lowers the pointer by two, and the new value is visible from cycle 2. It writes the low byte of `wr_data` to the new pointer address in cycle 2 and the high byte to that address plus one in cycle 3, with no other write. `done` is high in cycle 4 only.
- R3: A register restore (code 1) reads the pointer address in cycle 2 and that address plus one in cycle 3. It then raises the pointer by two, and `rd_data` equals {byte at pointer+1, byte at pointer} in cycle 4, the cycle in which `done` is high. It performs no write.
- R4: A call save (code 2) makes the same pointer change and the same two writes as R2, and `done` is high in cycle 6 only.
- R5: A return restore (code 3) makes the same reads, result and pointer change as R3, and `done` is high in cycle 6 only.
- R6: A pointer load (code 4) sets the pointer to `wr_data[7:0]` and ignores `wr_data[15:8]`. It performs no memory write, and `done` is high in cycle 2.
- R7: A pointer read (code 5) sets `rd_data` to {0x00, pointer} and leaves the pointer unchanged. `done` is high in cycle 2.
- R8: Pointer arithmetic and the second-byte address wrap modulo 256, and `mem_addr[15:8]` is always zero. For example, a save with the pointer at 0x00 writes 0xFE and 0xFF, and a restore with the pointer at 0xFF reads 0xFF and then 0x00 and leaves the pointer at 0x01.
- R9: A strobe raised while an operation is in progress is ignored, and so are codes 6 and 7. Neither produces a write, a `done` pulse or a pointer change.
- R10: `done` lasts exactly one cycle per operation. `rd_data` holds its value until the next restore or pointer read updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, sampled while idle |
| op_code | input | 3 | 0 save, 1 restore, 2 call save, 3 return restore, 4 pointer load, 5 pointer read |
| wr_data | input | 16 | Value to save, or the new pointer in bits 7:0 |
| rd_data | output | 16 | Restored value or pointer read result |
| sp | output | 16 | Current stack pointer, zero-extended |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Byte address, always within 0x0000 to 0x00FF |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Byte write enable |
| mem_rdata | input | 8 | Combinational read byte for `mem_addr` |

## Verification
The conditions hardest to reach from the ports are the page edge and a strobe that arrives in the middle of an operation. At the page edge, the second byte of a transfer lands on address 0x00 while the pointer sits at 0xFF. Directed steps first load the pointer to 0x00 and 0xFF and then save and restore across the boundary. Randomly chosen operations then inject stray pointer-load strobes in cycle 3 of longer operations, mixed with the unused codes. A bench-side shadow of the page predicts every restored value.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_SPLD = 3'd4,
        OP_SPRD = 3'd5
    } stk_op_e;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic op_writes(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

    function automatic logic op_reads(input stk_op_e op);
        return (op == OP_POP) || (op == OP_RET);
    endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int REG_CYC  = 4,
    parameter int SUB_CYC  = 6,
    parameter int XFER_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid_i,
    input  logic [2:0] op_code_i,
    output logic       accept_o,
    output stk_op_e    op_o,
    output logic       lo_o,
    output logic       hi_o,
    output logic       done_o
);

    localparam int MAX_AB = (REG_CYC > SUB_CYC) ? REG_CYC : SUB_CYC;
    localparam int MAX_C  = (MAX_AB > XFER_CYC) ? MAX_AB : XFER_CYC;
    localparam int PHW    = $clog2(MAX_C + 1);

    typedef struct packed {
        logic           busy;
        stk_op_e        op;
        logic [PHW-1:0] phase;
    } seq_t;

    seq_t s_q, s_d;
    logic [PHW-1:0] len;
    logic           mem_op;

    always_comb begin
        case (s_q.op)
            OP_PUSH, OP_POP: len = PHW'(REG_CYC);
            OP_CALL, OP_RET: len = PHW'(SUB_CYC);
            default:         len = PHW'(XFER_CYC);
        endcase
        mem_op   = op_writes(s_q.op) || op_reads(s_q.op);
        done_o   = s_q.busy && (s_q.phase == len);
        accept_o = op_valid_i && !s_q.busy && op_legal(op_code_i);
        lo_o     = s_q.busy && mem_op && (s_q.phase == PHW'(2));
        hi_o     = s_q.busy && mem_op && (s_q.phase == PHW'(3));
        op_o     = s_q.op;

        s_d = s_q;
        if (accept_o) begin
            s_d.busy  = 1'b1;
            s_d.op    = stk_op_e'(op_code_i);
            s_d.phase = PHW'(2);
        end else if (s_q.busy) begin
            if (done_o) s_d.busy = 1'b0;
            else        s_d.phase = s_q.phase + PHW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{busy: 1'b0, op: OP_PUSH, phase: '0};
        else        s_q <= s_d;
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !done_o) |=> (s_q.busy && s_q.op == $past(s_q.op)));

    assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_o |-> $past(lo_o));

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  stk_op_e       new_op_i,
    input  logic [AW-1:0] ld_val_i,
    input  logic          inc_i,
    input  logic          hi_sel_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] STEP = AW'(2);

    typedef struct packed {
        logic [AW-1:0] sp;
    } ptr_t;

    ptr_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (accept_i) begin
            case (new_op_i)
                OP_PUSH, OP_CALL: p_d.sp = p_q.sp - STEP;
                OP_SPLD:          p_d.sp = ld_val_i;
                default:          p_d.sp = p_q.sp;
            endcase
        end else if (inc_i) begin
            p_d.sp = p_q.sp + STEP;
        end
        sp_o   = p_q.sp;
        addr_o = p_q.sp + AW'(hi_sel_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{sp: '0};
        else        p_q <= p_d;
    end

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && (new_op_i == OP_PUSH || new_op_i == OP_CALL))
        |=> (p_q.sp == $past(p_q.sp) - STEP));

    assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (p_q.sp == $past(p_q.sp) + STEP));

endmodule

// File: rtl/stk_lane.sv
module stk_lane
    import stk_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  stk_op_e       new_op_i,
    input  logic [DW-1:0] wr_data_i,
    input  stk_op_e       cur_op_i,
    input  logic          lo_i,
    input  logic          hi_i,
    input  logic [DW/2-1:0] rdata_i,
    input  logic [AW-1:0] sp_i,
    output logic          mem_we_o,
    output logic [DW/2-1:0] mem_wdata_o,
    output logic [DW-1:0] result_o
);

    localparam int BW = DW / 2;

    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] result;
    } lane_t;

    lane_t l_q, l_d;
    logic  rd_op;

    always_comb begin
        rd_op = op_reads(cur_op_i);
        l_d   = l_q;
        if (accept_i) begin
            l_d.hold = wr_data_i;
            if (new_op_i == OP_SPRD) l_d.result = DW'(sp_i);
        end else if (rd_op && lo_i) begin
            l_d.hold[BW-1:0] = rdata_i;
        end else if (rd_op && hi_i) begin
            l_d.result = {rdata_i, l_q.hold[BW-1:0]};
        end
        mem_we_o    = op_writes(cur_op_i) && (lo_i || hi_i);
        mem_wdata_o = hi_i ? l_q.hold[DW-1:BW] : l_q.hold[BW-1:0];
        result_o    = l_q.result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '{hold: '0, result: '0};
        else        l_q <= l_d;
    end

    assert_we_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && hi_i) |-> $past(mem_we_o));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !(rd_op && hi_i)) |=> $stable(l_q.result));

endmodule

// File: rtl/byte_stack_unit.sv
module byte_stack_unit
    import stk_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 8,
    parameter int PUSH_CYCLES = 4,
    parameter int CALL_CYCLES = 6,
    parameter int XFER_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sp,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/2-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W/2-1:0] mem_rdata
);

    logic          accept, lo, hi;
    stk_op_e       cur_op, new_op;
    logic [PAGE_W-1:0] sp_page, addr_page;

    assign new_op = stk_op_e'(op_code);

    stk_seq #(
        .REG_CYC (PUSH_CYCLES),
        .SUB_CYC (CALL_CYCLES),
        .XFER_CYC(XFER_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid_i(op_valid),
        .op_code_i (op_code),
        .accept_o  (accept),
        .op_o      (cur_op),
        .lo_o      (lo),
        .hi_o      (hi),
        .done_o    (done)
    );

    stk_ptr #(.AW(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .new_op_i(new_op),
        .ld_val_i(wr_data[PAGE_W-1:0]),
        .inc_i   (hi && op_reads(cur_op)),
        .hi_sel_i(hi),
        .sp_o    (sp_page),
        .addr_o  (addr_page)
    );

    stk_lane #(.DW(DATA_W), .AW(PAGE_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .new_op_i   (new_op),
        .wr_data_i  (wr_data),
        .cur_op_i   (cur_op),
        .lo_i       (lo),
        .hi_i       (hi),
        .rdata_i    (mem_rdata),
        .sp_i       (sp_page),
        .mem_we_o   (mem_we),
        .mem_wdata_o(mem_wdata),
        .result_o   (rd_data)
    );

    assign sp       = ADDR_W'(sp_page);
    assign mem_addr = ADDR_W'(addr_page);

endmodule

// File: tb/tb_byte_stack_unit.sv
module tb_byte_stack_unit;

    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data, sp, mem_addr;
    logic        done, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;

    always #(PERIOD/2) clk = ~clk;

    byte_stack_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_data(wr_data), .rd_data(rd_data), .sp(sp), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata)
    );

    logic [7:0] ram [256];
    logic [7:0] shadow [256];
    logic [7:0] sp_m;
    logic [15:0] last_rd;
    int n_chk = 0, n_fail = 0, n_wr = 0, n_done = 0, bad_hi = 0, cyc = 0;
    bit finished = 1'b0;

    assign mem_rdata = ram[mem_addr[7:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'(i * 7 + 3);
        end else begin
            if (mem_we) begin
                n_wr <= n_wr + 1;
                if (mem_addr[15:8] != 8'h00) bad_hi <= bad_hi + 1;
                ram[mem_addr[7:0]] <= mem_wdata;
            end
            if (done) n_done <= n_done + 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog all: actual %0d cycles expected < 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int op_cycles(input int code);
        case (code)
            0, 1:    return 4;
            2, 3:    return 6;
            default: return 2;
        endcase
    endfunction

    function automatic string op_tag(input int code);
        case (code)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_op(input int code, input logic [15:0] val, input bit stray);
        int len = op_cycles(code);
        string tag = op_tag(code);
        int w0, d0;
        logic [15:0] exp_rd;
        @(negedge clk);
        op_valid = 1'b1; op_code = code[2:0]; wr_data = val;
        w0 = n_wr; d0 = n_done;
        @(negedge clk);
        op_valid = 1'b0; wr_data = 16'($urandom);
        for (int k = 2; k <= len; k++) begin
            if (k > 2) @(negedge clk);
            if (stray && k == 3) begin
                op_valid = 1'b1; op_code = 3'd4; wr_data = 16'($urandom);
            end
            if (stray && k == 4) op_valid = 1'b0;
            check(tag, "done timing", 32'(done), 32'(k == len));
        end
        case (code)
            0, 2: begin
                sp_m = sp_m - 8'd2;
                shadow[sp_m] = val[7:0];
                shadow[8'(sp_m + 8'd1)] = val[15:8];
                check(tag, "pointer", 32'(sp), {24'h0, sp_m});
                check(tag, "low byte", 32'(ram[sp_m]), 32'(val[7:0]));
                check(tag, "high byte", 32'(ram[8'(sp_m + 8'd1)]), 32'(val[15:8]));
                check(tag, "write count", 32'(n_wr - w0), 32'd2);
                check("R10", "result hold", 32'(rd_data), 32'(last_rd));
            end
            1, 3: begin
                exp_rd = {shadow[8'(sp_m + 8'd1)], shadow[sp_m]};
                sp_m = sp_m + 8'd2;
                last_rd = exp_rd;
                check(tag, "result", 32'(rd_data), 32'(exp_rd));
                check(tag, "pointer", 32'(sp), {24'h0, sp_m});
                check(tag, "write count", 32'(n_wr - w0), 32'd0);
            end
            4: begin
                sp_m = val[7:0];
                check(tag, "pointer", 32'(sp), {24'h0, sp_m});
                check(tag, "write count", 32'(n_wr - w0), 32'd0);
                check("R10", "result hold", 32'(rd_data), 32'(last_rd));
            end
            default: begin
                last_rd = {8'h00, sp_m};
                check(tag, "result", 32'(rd_data), 32'(last_rd));
                check(tag, "pointer", 32'(sp), {24'h0, sp_m});
            end
        endcase
        @(negedge clk);
        check("R10", "done single pulse", 32'(done), 32'd0);
        check(stray ? "R9" : "R10", "done count", 32'(n_done - d0), 32'd1);
        if (stray) check("R9", "stray strobe pointer", 32'(sp), {24'h0, sp_m});
    endtask

    task automatic run_illegal(input int code);
        int w0 = n_wr, d0 = n_done;
        @(negedge clk);
        op_valid = 1'b1; op_code = code[2:0]; wr_data = 16'($urandom);
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "unused code writes", 32'(n_wr - w0), 32'd0);
        check("R9", "unused code done", 32'(n_done - d0), 32'd0);
        check("R9", "unused code pointer", 32'(sp), {24'h0, sp_m});
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_0042);
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
        sp_m = 8'h00;
        last_rd = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset pointer", 32'(sp), 32'h0);
        check("R1", "reset result", 32'(rd_data), 32'h0);
        check("R1", "reset done", 32'(done), 32'h0);
        check("R1", "reset write enable", 32'(mem_we), 32'h0);

        // R8: save from pointer 0x00 wraps to 0xFE/0xFF
        run_op(0, 16'hA55A, 1'b0);
        check("R8", "wrap pointer", 32'(sp), 32'h00FE);
        check("R8", "wrap byte at FF", 32'(ram[255]), 32'hA5);
        // R8: restore from 0xFF reads FF then 00
        run_op(4, 16'hC3FF, 1'b0);
        check("R6", "upper bits ignored", 32'(sp), 32'h00FF);
        run_op(1, 16'h0, 1'b0);
        check("R8", "wrap restore value", 32'(rd_data), {16'h0, ram[0], ram[255]});
        check("R8", "wrap pointer after restore", 32'(sp), 32'h0001);
        run_op(5, 16'h0, 1'b0);
        // call/return round trip and stray strobe in busy cycles
        run_op(2, 16'h1234, 1'b1);
        run_op(0, 16'hBEEF, 1'b1);
        run_op(1, 16'h0, 1'b1);
        check("R3", "restore returns saved value", 32'(rd_data), 32'hBEEF);
        run_op(3, 16'h0, 1'b0);
        check("R5", "return returns call value", 32'(rd_data), 32'h1234);
        run_illegal(6);
        run_illegal(7);

        for (int n = 0; n < 150; n++) begin
            int code = int'($urandom % 8);
            if (code >= 6) run_illegal(code);
            else run_op(code, 16'($urandom),
                        (op_cycles(code) >= 4) && ($urandom % 4 == 0));
        end

        check("R8", "upper address byte on writes", 32'(bad_hi), 32'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule